// File: doc/BRIEF.md
# Frame Interrupt Coalescing Counter

This block cuts down the number of frame-completion interrupts that a video DMA channel raises. Rather than interrupting once per frame, it counts finished frames down from a programmable threshold and raises a frame flag only when that many frames have completed. A second source, an inactivity timer, watches the gaps. When some frames have been counted but the threshold has not yet been reached, and no further frame arrives within a programmable number of timer ticks, the block raises a delay flag. Software then still learns about a partial batch.

The control logic supplies the two 8-bit thresholds through write strobes, the per-source interrupt enables, a soft reset, and write-one-to-clear acknowledge pulses. The frame counter and the delay timer both sit on the status word as live values. The block has no register decode and no datapath. The frame-done strobe and the timer tick come from the surrounding channel.

Top module: `irq_coalesce_unit`

## Requirements
- R1: After the reset input is asserted, the frame count reads the reset threshold (4 by default), the delay count reads 0, and both flags and the interrupt output are low.
- R2: Each frame-done strobe lowers the frame count by one. The strobe that arrives when the count reads 1 sets the frame flag and reloads the count to the threshold, so N strobes raise the flag once for a threshold of N. Without a strobe, write or soft reset, the count holds.
- R3: A frame threshold of 0 behaves as 1: the count reads 1 and every frame-done strobe sets the frame flag. The frame count never reads 0.
- R4: A frame-threshold write loads the new effective threshold into the count on the next clock. It takes priority over a frame-done strobe in the same cycle, and that strobe is discarded.
- R5: A frame-done strobe clears the delay count to 0. While frames are pending (frame count differs from the effective threshold) and the delay threshold is nonzero, each tick adds one to the delay count.
- R6: The tick that brings the delay count to the delay threshold sets the delay flag. Further ticks leave the count at the threshold.
- R7: Ticks leave the delay count at 0 when no frames are pending or when the delay threshold is 0. A delay-threshold write also clears the delay count.
- R8: An acknowledge pulse clears its own flag on the next clock. A set in the same cycle wins over the acknowledge.
- R9: The interrupt output is high exactly when a flag is high and its enable is high.
- R10: Soft reset returns the frame count to the effective threshold and the delay count to 0, and clears both flags. It overrides any strobe, tick or acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset of counters and flags |
| frame_done | input | 1 | One-cycle pulse per completed frame |
| tick | input | 1 | Delay timer time base pulse |
| frm_thr_wr | input | 1 | Frame threshold write strobe |
| frm_thr_in | input | CNT_W | Frame threshold value |
| dly_thr_wr | input | 1 | Delay threshold write strobe |
| dly_thr_in | input | DLY_W | Delay threshold value (0 disables the timer) |
| frm_irq_en | input | 1 | Frame flag interrupt enable |
| dly_irq_en | input | 1 | Delay flag interrupt enable |
| frm_ack | input | 1 | Write-one-to-clear for the frame flag |
| dly_ack | input | 1 | Write-one-to-clear for the delay flag |
| frm_flag | output | 1 | Frame-count interrupt flag |
| dly_flag | output | 1 | Delay interrupt flag |
| irq | output | 1 | Enabled OR of the flags |
| frm_count | output | CNT_W | Live frame counter |
| dly_count | output | DLY_W | Live delay counter |

## Verification
The properties assume that frame_done, tick and the acknowledge and write strobes are synchronous to clk and free of X once reset is released. They make no assumption about spacing: a strobe may sit next to a write or a soft reset in the same cycle, and the properties name those exclusions explicitly. The stimulus changes every input a short time after a rising edge and holds it for one full cycle, so each pulse is seen by exactly one edge. The collision cases (write with strobe, set with acknowledge, soft reset with everything) are driven on purpose to reach the priority rules.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum int unsigned {
      SRC_FRM = 0,
      SRC_DLY = 1
   } irq_src_e;

   localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/irqc_frame_ctr.sv
module irqc_frame_ctr #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_THR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             thr_wr,
   input  logic [CNT_W-1:0] thr_in,
   input  logic             frame_done,
   output logic [CNT_W-1:0] count,
   output logic             pending,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] RST_RAW = CNT_W'(RST_THR);
   localparam logic [CNT_W-1:0] RST_EFF = (RST_RAW == '0) ? ONE : RST_RAW;

   logic [CNT_W-1:0] thr_q;
   logic [CNT_W-1:0] thr_nxt;
   logic [CNT_W-1:0] eff_q;
   logic [CNT_W-1:0] eff_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             reload;

   always_comb begin
      thr_nxt = thr_wr ? thr_in : thr_q;
      eff_q   = (thr_q == '0) ? ONE : thr_q;
      eff_nxt = (thr_nxt == '0) ? ONE : thr_nxt;
      reload  = soft_rst || thr_wr;
      wrap    = frame_done && !reload && (cnt_q == ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= RST_RAW;
      end else begin
         thr_q <= thr_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_EFF;
      end else if (reload) begin
         cnt_q <= eff_nxt;
      end else if (frame_done) begin
         if (cnt_q == ONE) begin
            cnt_q <= eff_q;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign count   = cnt_q;
   assign pending = (cnt_q != eff_q);
endmodule

// File: rtl/irqc_delay_timer.sv
module irqc_delay_timer #(
   parameter int unsigned DLY_W   = 8,
   parameter int unsigned RST_THR = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             thr_wr,
   input  logic [DLY_W-1:0] thr_in,
   input  logic             frame_done,
   input  logic             tick,
   input  logic             pending,
   output logic [DLY_W-1:0] count,
   output logic             hit
);
   localparam logic [DLY_W-1:0] ONE     = DLY_W'(1);
   localparam logic [DLY_W-1:0] RST_RAW = DLY_W'(RST_THR);

   logic [DLY_W-1:0] thr_q;
   logic [DLY_W-1:0] cnt_q;
   logic             clear;
   logic             active;
   logic             run;

   always_comb begin
      clear  = soft_rst || thr_wr || frame_done;
      active = (thr_q != '0);
      run    = tick && pending && active && !clear && (cnt_q != thr_q);
      hit    = run && (cnt_q == (thr_q - ONE));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= RST_RAW;
      end else if (thr_wr) begin
         thr_q <= thr_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/irqc_flag_cell.sv
module irqc_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic set,
   input  logic ack,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (soft_rst) begin
         flag_q <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
      end else if (ack) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned DLY_W       = 8,
   parameter int unsigned FRM_THR_RST = 4,
   parameter int unsigned DLY_THR_RST = 0,
   parameter bit          REG_IRQ     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             frame_done,
   input  logic             tick,
   input  logic             frm_thr_wr,
   input  logic [CNT_W-1:0] frm_thr_in,
   input  logic             dly_thr_wr,
   input  logic [DLY_W-1:0] dly_thr_in,
   input  logic             frm_irq_en,
   input  logic             dly_irq_en,
   input  logic             frm_ack,
   input  logic             dly_ack,
   output logic             frm_flag,
   output logic             dly_flag,
   output logic             irq,
   output logic [CNT_W-1:0] frm_count,
   output logic [DLY_W-1:0] dly_count
);
   import irqc_pkg::*;

   localparam int unsigned FRM_MAX = (1 << CNT_W) - 1;
   localparam int unsigned DLY_MAX = (1 << DLY_W) - 1;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("CNT_W must lie in 1..16");
      end
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly_w
         $error("DLY_W must lie in 1..16");
      end
      if (FRM_THR_RST > FRM_MAX) begin : g_bad_frm_rst
         $error("FRM_THR_RST does not fit in CNT_W bits");
      end
      if (DLY_THR_RST > DLY_MAX) begin : g_bad_dly_rst
         $error("DLY_THR_RST does not fit in DLY_W bits");
      end
   endgenerate

   logic               pending;
   logic               frm_wrap;
   logic               dly_hit;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] ack_vec;
   logic [NUM_SRC-1:0] en_vec;
   logic [NUM_SRC-1:0] flag_vec;
   logic               irq_raw;

   irqc_frame_ctr #(
      .CNT_W   (CNT_W),
      .RST_THR (FRM_THR_RST)
   ) u_frame_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .thr_wr     (frm_thr_wr),
      .thr_in     (frm_thr_in),
      .frame_done (frame_done),
      .count      (frm_count),
      .pending    (pending),
      .wrap       (frm_wrap)
   );

   irqc_delay_timer #(
      .DLY_W   (DLY_W),
      .RST_THR (DLY_THR_RST)
   ) u_delay_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .thr_wr     (dly_thr_wr),
      .thr_in     (dly_thr_in),
      .frame_done (frame_done),
      .tick       (tick),
      .pending    (pending),
      .count      (dly_count),
      .hit        (dly_hit)
   );

   always_comb begin
      set_vec          = '0;
      ack_vec          = '0;
      en_vec           = '0;
      set_vec[SRC_FRM] = frm_wrap;
      set_vec[SRC_DLY] = dly_hit;
      ack_vec[SRC_FRM] = frm_ack;
      ack_vec[SRC_DLY] = dly_ack;
      en_vec[SRC_FRM]  = frm_irq_en;
      en_vec[SRC_DLY]  = dly_irq_en;
   end

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
         irqc_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .set      (set_vec[s]),
            .ack      (ack_vec[s]),
            .flag     (flag_vec[s])
         );
      end
   endgenerate

   assign frm_flag = flag_vec[SRC_FRM];
   assign dly_flag = flag_vec[SRC_DLY];
   assign irq_raw  = |(flag_vec & en_vec);

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= irq_raw;
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DLY_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             frame_done,
   input logic             tick,
   input logic             frm_thr_wr,
   input logic             dly_thr_wr,
   input logic             frm_ack,
   input logic             dly_ack,
   input logic             frm_flag,
   input logic             dly_flag,
   input logic [CNT_W-1:0] frm_count,
   input logic [DLY_W-1:0] dly_count
);
   AST_FRM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !soft_rst && !frm_thr_wr && frm_count > CNT_W'(1))
      |=> (frm_count == CNT_W'($past(frm_count) - CNT_W'(1)))); // R2

   AST_FRM_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !soft_rst && !frm_thr_wr && frm_count == CNT_W'(1))
      |=> frm_flag); // R2

   AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !soft_rst && !frm_thr_wr) |=> $stable(frm_count)); // R2

   AST_FRM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_count != '0)); // R3

   AST_DLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (dly_count == '0)); // R5

   AST_DLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !soft_rst && !dly_thr_wr)
      |=> (dly_count == $past(dly_count) ||
           dly_count == DLY_W'($past(dly_count) + DLY_W'(1)))); // R5

   AST_DLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !frame_done && !soft_rst && !dly_thr_wr) |=> $stable(dly_count)); // R7

   AST_DLY_ROSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dly_flag) |-> $past(tick)); // R6

   AST_FRM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_ack && !frame_done) |=> !frm_flag); // R8

   AST_DLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_ack && !tick) |=> !dly_flag); // R8

   AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dly_count == '0 && !frm_flag && !dly_flag)); // R10
endmodule

bind irq_coalesce_unit irqc_checker #(
   .CNT_W (CNT_W),
   .DLY_W (DLY_W)
) u_irqc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .frame_done (frame_done),
   .tick       (tick),
   .frm_thr_wr (frm_thr_wr),
   .dly_thr_wr (dly_thr_wr),
   .frm_ack    (frm_ack),
   .dly_ack    (dly_ack),
   .frm_flag   (frm_flag),
   .dly_flag   (dly_flag),
   .frm_count  (frm_count),
   .dly_count  (dly_count)
);

// File: tb/irq_coalesce_unit_tb_top.sv
`timescale 1ns/1ps
module irq_coalesce_unit_tb_top;
   localparam int CW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          frame_done = 1'b0;
   logic          tick = 1'b0;
   logic          frm_thr_wr = 1'b0;
   logic [CW-1:0] frm_thr_in = '0;
   logic          dly_thr_wr = 1'b0;
   logic [DW-1:0] dly_thr_in = '0;
   logic          frm_irq_en = 1'b0;
   logic          dly_irq_en = 1'b0;
   logic          frm_ack = 1'b0;
   logic          dly_ack = 1'b0;
   logic          frm_flag;
   logic          dly_flag;
   logic          irq;
   logic [CW-1:0] frm_count;
   logic [DW-1:0] dly_count;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_coalesce_unit #(
      .CNT_W (CW),
      .DLY_W (DW)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .frame_done (frame_done),
      .tick       (tick),
      .frm_thr_wr (frm_thr_wr),
      .frm_thr_in (frm_thr_in),
      .dly_thr_wr (dly_thr_wr),
      .dly_thr_in (dly_thr_in),
      .frm_irq_en (frm_irq_en),
      .dly_irq_en (dly_irq_en),
      .frm_ack    (frm_ack),
      .dly_ack    (dly_ack),
      .frm_flag   (frm_flag),
      .dly_flag   (dly_flag),
      .irq        (irq),
      .frm_count  (frm_count),
      .dly_count  (dly_count)
   );

   task automatic chk(input string what, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #2;
      soft_rst   = 1'b0;
      frame_done = 1'b0;
      tick       = 1'b0;
      frm_thr_wr = 1'b0;
      dly_thr_wr = 1'b0;
      frm_ack    = 1'b0;
      dly_ack    = 1'b0;
   endtask

   task automatic frame();
      frame_done = 1'b1;
      cyc();
   endtask

   task automatic tick1();
      tick = 1'b1;
      cyc();
   endtask

   task automatic set_frm_thr(input int v);
      frm_thr_in = CW'(v);
      frm_thr_wr = 1'b1;
      cyc();
   endtask

   task automatic set_dly_thr(input int v);
      dly_thr_in = DW'(v);
      dly_thr_wr = 1'b1;
      cyc();
   endtask

   task automatic t_reset();
      chk("R1 frame count after reset", frm_count, 4);
      chk("R1 delay count after reset", dly_count, 0);
      chk("R1 frame flag after reset", frm_flag, 0);
      chk("R1 delay flag after reset", dly_flag, 0);
      chk("R1 irq after reset", irq, 0);
   endtask

   task automatic t_count();
      set_frm_thr(3);
      chk("R4 count after threshold write", frm_count, 3);
      frame();
      chk("R2 count after 1 frame", frm_count, 2);
      cyc();
      chk("R2 count holds without strobe", frm_count, 2);
      frame();
      chk("R2 count after 2 frames", frm_count, 1);
      chk("R2 no flag before threshold", frm_flag, 0);
      frame();
      chk("R2 flag at threshold", frm_flag, 1);
      chk("R2 reload after wrap", frm_count, 3);
   endtask

   task automatic t_ack();
      frm_ack = 1'b1;
      cyc();
      chk("R8 ack clears frame flag", frm_flag, 0);
      frame();
      frame();
      frame_done = 1'b1;
      frm_ack    = 1'b1;
      cyc();
      chk("R8 set wins over ack", frm_flag, 1);
      frm_ack = 1'b1;
      cyc();
      chk("R8 ack clears after collision", frm_flag, 0);
   endtask

   task automatic t_zero();
      set_frm_thr(0);
      chk("R3 zero threshold reads 1", frm_count, 1);
      frame();
      chk("R3 every frame sets flag", frm_flag, 1);
      chk("R3 count stays 1", frm_count, 1);
      frm_ack = 1'b1;
      cyc();
      frame();
      chk("R3 second frame sets flag again", frm_flag, 1);
      frm_ack = 1'b1;
      cyc();
   endtask

   task automatic t_wr_prio();
      set_frm_thr(5);
      frame();
      chk("R2 count 5 to 4", frm_count, 4);
      frm_thr_in = 8'd6;
      frm_thr_wr = 1'b1;
      frame_done = 1'b1;
      cyc();
      chk("R4 write beats frame strobe", frm_count, 6);
      chk("R4 no flag from discarded strobe", frm_flag, 0);
   endtask

   task automatic t_delay();
      set_dly_thr(3);
      chk("R7 delay write clears count", dly_count, 0);
      for (int i = 0; i < 5; i++) tick1();
      chk("R7 no counting without pending frames", dly_count, 0);
      frame();
      chk("R5 pending frame count", frm_count, 5);
      tick1();
      chk("R5 delay count 1", dly_count, 1);
      tick1();
      chk("R5 delay count 2", dly_count, 2);
      chk("R6 no delay flag below threshold", dly_flag, 0);
      tick1();
      chk("R6 delay flag at threshold", dly_flag, 1);
      chk("R6 delay count at threshold", dly_count, 3);
      tick1();
      chk("R6 delay count saturates", dly_count, 3);
      frame();
      chk("R5 frame clears delay count", dly_count, 0);
      chk("R5 delay flag sticky", dly_flag, 1);
      dly_ack = 1'b1;
      cyc();
      chk("R8 ack clears delay flag", dly_flag, 0);
      set_dly_thr(0);
      for (int i = 0; i < 4; i++) tick1();
      chk("R7 zero delay threshold disables timer", dly_count, 0);
      chk("R7 no delay flag when disabled", dly_flag, 0);
   endtask

   task automatic t_irq();
      set_frm_thr(1);
      frame();
      chk("R9 flag set but disabled", frm_flag, 1);
      chk("R9 irq low when disabled", irq, 0);
      frm_irq_en = 1'b1;
      cyc();
      chk("R9 irq high when enabled", irq, 1);
      dly_irq_en = 1'b1;
      frm_irq_en = 1'b0;
      cyc();
      chk("R9 other enable does not pass frame flag", irq, 0);
      frm_ack = 1'b1;
      cyc();
      dly_irq_en = 1'b0;
   endtask

   task automatic t_soft();
      set_frm_thr(3);
      set_dly_thr(2);
      frame();
      tick1();
      tick1();
      chk("R6 delay flag before soft reset", dly_flag, 1);
      frame();
      frame();
      chk("R2 frame flag before soft reset", frm_flag, 1);
      frame();
      chk("R2 count before soft reset", frm_count, 2);
      soft_rst   = 1'b1;
      frame_done = 1'b1;
      tick       = 1'b1;
      cyc();
      chk("R10 soft reset reloads frame count", frm_count, 3);
      chk("R10 soft reset clears delay count", dly_count, 0);
      chk("R10 soft reset clears frame flag", frm_flag, 0);
      chk("R10 soft reset clears delay flag", dly_flag, 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_count();
      t_ack();
      t_zero();
      t_wr_prio();
      t_delay();
      t_irq();
      t_soft();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule